// File: doc/BRIEF.md
# Dual-channel serial result shifter

This block is the converter-side output path for two 14-bit conversion results. A host lowers chip-select and toggles the serial clock. The block then sends a frame on each of two data lines, and the data changes after each falling edge of the serial clock. Each line starts with two zero bits, followed by its own channel's 14-bit result, MSB first. If chip-select stays low past that point, the same line goes on to send two more zero bits and the other channel's result. This lets a host read both results over a single wire.

Results reach the block on two 14-bit parallel buses qualified by a valid strobe, and they are held internally. At each chip-select falling edge the held values are copied into two 32-bit frame registers, so the values being sent cannot change during a frame. Each data line has its own output enable, which a pad uses to three-state the line. Both enables drop as soon as chip-select rises. They also drop on the 32nd serial clock falling edge of a frame, even if chip-select is still low. Chip-select and serial clock are sampled on the system clock `clk` and must already be synchronous to it.

Top module: `dual_result_shifter`

## Requirements
- R1: While reset is asserted and after it is released, with chip-select high, both output enables are 0 and both data lines are 0.
- R2: One `clk` cycle after chip-select is sampled low, following a high sample, both enables are 1. After k serial clock falling edges (k = 0..15), line A sends bit (31-k) of the word {2'b00, A[13:0], 2'b00, B[13:0]}. So the two leading zeros come first, then A, MSB first.
- R3: Over the same edges, line B sends bit (31-k) of the word {2'b00, B[13:0], 2'b00, A[13:0]}.
- R4: If chip-select stays low after the 16th falling edge, falling edges 16 to 31 continue the same words on the same lines. Each line sends two zero bits and then the other channel's result, MSB first.
- R5: From chip-select low until the 31st falling edge, both lines stay enabled. This includes the span after the 16th edge.
- R6: On the 32nd falling edge of a frame, both enables go to 0 and stay at 0 while chip-select stays low, however many further edges arrive.
- R7: When chip-select is high, both enables are 0 in the same cycle, with no clock edge needed. This applies to a rise at any point in a frame, including before the 16th edge, which aborts the frame.
- R8: A result-valid pulse during a frame does not change the bits sent in that frame. The new values are sent in the next frame.
- R9: If the result-valid pulse and the chip-select falling edge are sampled in the same cycle, the frame carries the new results.
- R10: Serial clock falling edges while chip-select is high have no effect. The next frame still starts at bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip-select; a high-to-low change starts a frame |
| sclk | input | 1 | Serial clock; data advances on its falling edges |
| res_a | input | 14 | Channel A conversion result |
| res_b | input | 14 | Channel B conversion result |
| res_valid | input | 1 | Strobe that captures res_a and res_b |
| sd_a | output | 1 | Data line A (channel A first) |
| sd_b | output | 1 | Data line B (channel B first) |
| oe_a | output | 1 | Drive enable for line A |
| oe_b | output | 1 | Drive enable for line B |

## Verification
Two functions can fall in the same cycle: capturing a fresh result and loading a frame. The bench makes them collide by raising the valid strobe in the same cycle that chip-select is first sampled low. It then checks that all 32 bits on both lines carry the new values. For the opposite case, the bench sends a valid pulse partway through a frame. That frame must still carry the old values, and the next frame must carry the new ones. Chip-select rising on the same cycle as a serial clock edge is judged by requiring both enables to be low before any further edge.

// File: rtl/dual_result_shifter.sv
module dual_result_shifter #(
  parameter int W   = 14,
  parameter int PAD = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic [W-1:0] res_a,
  input  logic [W-1:0] res_b,
  input  logic         res_valid,
  output logic         sd_a,
  output logic         sd_b,
  output logic         oe_a,
  output logic         oe_b
);

  localparam int HALF = W + PAD;
  localparam int FW   = 2 * HALF;
  localparam int CW   = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);

  logic          sclk_q, cs_q;
  logic [W-1:0]  hold_a, hold_b;
  logic [FW-1:0] sh_a, sh_b;
  logic [CW-1:0] cnt;
  logic          active;

  wire sclk_fall = sclk_q & ~sclk;
  wire cs_fall   = cs_q & ~cs_n;
  wire [W-1:0] cap_a = res_valid ? res_a : hold_a;
  wire [W-1:0] cap_b = res_valid ? res_b : hold_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (res_valid) begin
        hold_a <= res_a;
        hold_b <= res_b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_a   <= '0;
      sh_b   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (cs_fall) begin
      sh_a   <= {PAD'(0), cap_a, PAD'(0), cap_b};
      sh_b   <= {PAD'(0), cap_b, PAD'(0), cap_a};
      cnt    <= '0;
      active <= 1'b1;
    end else if (cs_n) begin
      active <= 1'b0;
    end else if (active && sclk_fall) begin
      sh_a <= sh_a << 1;
      sh_b <= sh_b << 1;
      cnt  <= cnt + 1'b1;
      if (cnt == LAST) active <= 1'b0;
    end
  end

  assign oe_a = active & ~cs_n;
  assign oe_b = active & ~cs_n;
  assign sd_a = oe_a & sh_a[FW-1];
  assign sd_b = oe_b & sh_b[FW-1];

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> active && cnt == '0);

  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sclk_fall && !cs_n && !cs_fall) |=> sh_a == ($past(sh_a) << 1) && sh_b == ($past(sh_b) << 1));

  a_r8_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sclk_fall && !cs_fall) |=> $stable(sh_a) && $stable(sh_b));

  a_r6_end_of_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sclk_fall && !cs_n && !cs_fall && cnt == LAST) |=> !oe_a && !oe_b);

  a_r6_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cs_fall) |=> !active);

  a_r10_no_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cs_fall) |=> $stable(cnt));

endmodule

// File: tb/sim_dual_result_shifter.sv
module sim_dual_result_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic [13:0] res_a = '0, res_b = '0;
  logic res_valid = 1'b0;
  logic sd_a, sd_b, oe_a, oe_b;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_result_shifter u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .res_a(res_a), .res_b(res_b), .res_valid(res_valid),
    .sd_a(sd_a), .sd_b(sd_b), .oe_a(oe_a), .oe_b(oe_b)
  );

  // {a, b, falling edges before chip-select rises}
  localparam logic [33:0] VEC [6] = '{
    {14'h3FFF, 14'h0000, 6'd32},
    {14'h2A5C, 14'h15A3, 6'd32},
    {14'h0001, 14'h2000, 6'd16},
    {14'h1234, 14'h0ABC, 6'd18},
    {14'h3C3C, 14'h0F0F, 6'd5},
    {14'h1FFE, 14'h2001, 6'd24}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_pos(input string tag, input logic [31:0] wa, input logic [31:0] wb, input int k);
    logic eo;
    eo = (k < 32);
    chk({tag, " oe_a"}, oe_a, eo);
    chk({tag, " oe_b"}, oe_b, eo);
    chk({tag, " sd_a"}, sd_a, eo ? wa[31-k] : 1'b0);
    chk({tag, " sd_b"}, sd_b, eo ? wb[31-k] : 1'b0);
  endtask

  task automatic load(input logic [13:0] a, input logic [13:0] b);
    @(negedge clk); res_a = a; res_b = b; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic fall_edge;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cs_low;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_high(input string tag);
    @(negedge clk); cs_n = 1'b1;
    #1;
    chk({tag, " R7 oe_a on cs rise"}, oe_a, 1'b0);
    chk({tag, " R7 oe_b on cs rise"}, oe_b, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] word(input logic [13:0] x, input logic [13:0] y);
    return {2'b00, x, 2'b00, y};
  endfunction

  task automatic frame(input string tag, input logic [13:0] a, input logic [13:0] b, input int n);
    cs_low();
    chk_pos({tag, " R2/R3 k=0"}, word(a, b), word(b, a), 0);
    for (int k = 1; k <= n; k++) begin
      fall_edge();
      chk_pos($sformatf("%s R2/R3/R4/R5/R6 k=%0d", tag, k), word(a, b), word(b, a), k);
    end
    cs_high(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe_a in reset", oe_a, 1'b0);
    chk("R1 sd_a in reset", sd_a, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe_b after reset", oe_b, 1'b0);
    chk("R1 sd_b after reset", sd_b, 1'b0);

    for (int i = 0; i < 6; i++) begin
      load(VEC[i][33:20], VEC[i][19:6]);
      frame($sformatf("vec%0d", i), VEC[i][33:20], VEC[i][19:6], int'(VEC[i][5:0]));
    end

    // R6: extra edges after the 32nd keep lines released
    load(14'h2BCD, 14'h1357);
    cs_low();
    for (int k = 1; k <= 40; k++) begin
      fall_edge();
      chk_pos($sformatf("R6 long k=%0d", k), word(14'h2BCD, 14'h1357), word(14'h1357, 14'h2BCD), k);
    end
    cs_high("R6 long");

    // R8: a result update during a frame affects only the next frame
    load(14'h0AAA, 14'h3555);
    cs_low();
    for (int k = 1; k <= 32; k++) begin
      fall_edge();
      if (k == 3) load(14'h3111, 14'h0222);
      chk_pos($sformatf("R8 old k=%0d", k), word(14'h0AAA, 14'h3555), word(14'h3555, 14'h0AAA), k);
    end
    cs_high("R8");
    frame("R8 next", 14'h3111, 14'h0222, 32);

    // R9: valid strobe on the same cycle as the chip-select fall
    @(negedge clk); cs_n = 1'b0; res_a = 14'h1ABC; res_b = 14'h2DEF; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
    chk_pos("R9 k=0", word(14'h1ABC, 14'h2DEF), word(14'h2DEF, 14'h1ABC), 0);
    for (int k = 1; k <= 32; k++) begin
      fall_edge();
      chk_pos($sformatf("R9 k=%0d", k), word(14'h1ABC, 14'h2DEF), word(14'h2DEF, 14'h1ABC), k);
    end
    cs_high("R9");

    // R10: edges with chip-select high do nothing
    load(14'h3FFF, 14'h3FFF);
    for (int k = 0; k < 5; k++) begin
      fall_edge();
      chk("R10 oe_a idle", oe_a, 1'b0);
      chk("R10 sd_a idle", sd_a, 1'b0);
    end
    frame("R10 after idle edges", 14'h3FFF, 14'h3FFF, 20);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule